// File: doc/BRIEF.md
# Multicycle Datapath Sequencer

This block is the control unit for a multicycle processor datapath. On every clock it presents a complete set of control levels to the datapath: the program-counter load enables, the memory address source, the memory strobes, the instruction-register load, the register-file write controls, and the ALU operand and mode selects. It is a Moore machine. Its outputs depend only on the current step, and it reads the 6-bit opcode from the instruction register only when it chooses a branch of its sequence.

Every instruction starts with a fetch step and a decode step. The machine then branches on the opcode. Loads take five cycles, stores and register-to-register operations take four, and conditional branches and jumps take three. Memory instructions branch a second time after the address step, where load and store part. An opcode that is not recognised sends the machine from decode straight back to fetch.

Top module: `mc_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, and at once when it falls in the middle of an instruction, the outputs show the fetch pattern of R2. After `rst_n` rises, fetch is held for two more clock edges.
- R2: The fetch step drives `mem_rd`=1, `instr_ld`=1, `pc_ld`=1, `pc_src`=00 (incremented PC), `addr_sel_alu`=0, `alu_a_sel`=0, `alu_b_sel`=01 (constant 4) and `alu_mode`=00 (add). All other outputs are 0.
- R3: Fetch is always followed by the decode step, whatever the opcode. Decode drives `alu_a_sel`=0, `alu_b_sel`=11 (shifted immediate) and `alu_mode`=00, with every enable low.
- R4: After decode, the opcode selects the next step: 100011 (load) and 101011 (store) go to the address step, 000000 goes to register execute, 000100 goes to branch, and 000010 goes to jump.
- R5: The address step drives `alu_a_sel`=1, `alu_b_sel`=10 (immediate) and `alu_mode`=00. It is followed by the load read step for opcode 100011 and by the store step for opcode 101011.
- R6: The load read step drives `mem_rd`=1 and `addr_sel_alu`=1. It is followed by load write-back, which drives `rf_wr`=1, `wb_sel_mem`=1 and `rf_dst_sel`=0.
- R7: The store step drives `mem_wr`=1 and `addr_sel_alu`=1, and is followed by fetch.
- R8: Register execute drives `alu_a_sel`=1, `alu_b_sel`=00 and `alu_mode`=10 (function field). It is followed by register write-back, which drives `rf_wr`=1, `rf_dst_sel`=1 and `wb_sel_mem`=0, and then by fetch.
- R9: The branch step drives `alu_a_sel`=1, `alu_b_sel`=00, `alu_mode`=01 (subtract), `pc_ld_if_zero`=1 and `pc_src`=01 (branch target), and is followed by fetch.
- R10: The jump step drives `pc_ld`=1 and `pc_src`=10 (jump target), and is followed by fetch.
- R11: Any other opcode seen in decode returns the machine to fetch on the next cycle.
- R12: Counted from fetch to the next fetch, the sequence lasts 5 cycles for a load, 4 for a store or register operation, 3 for a branch or jump, and 2 for an unrecognised opcode.
- R13: `mem_rd` and `mem_wr` are never high in the same cycle, and neither are `pc_ld` and `pc_ld_if_zero`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field from the instruction register |
| pc_ld | output | 1 | Unconditional program-counter load |
| pc_ld_if_zero | output | 1 | Program-counter load when the ALU result is zero |
| addr_sel_alu | output | 1 | Memory address from the ALU result register (0: from PC) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| instr_ld | output | 1 | Instruction-register load |
| wb_sel_mem | output | 1 | Register write data from the memory data register (0: ALU result) |
| pc_src | output | 2 | Next-PC source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_mode | output | 2 | ALU mode: 00 add, 01 subtract, 10 by function field |
| alu_a_sel | output | 1 | ALU operand A: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU operand B: 00 register B, 01 four, 10 immediate, 11 shifted immediate |
| rf_wr | output | 1 | Register-file write enable |
| rf_dst_sel | output | 1 | Destination register from the rd field (0: rt field) |

## Verification
The assertions are evaluated on every cycle and check the local structure of the sequence. They check that fetch carries its full pattern and is always followed by decode, that jump and unrecognised opcodes are dispatched correctly from decode, and that stores and branches return to fetch. They also check that load reads lead to write-back, that register execute leads to its write-back, and that the exclusive strobe pairs never overlap. Only the bench scenarios can show the whole cycle-by-cycle pattern of each instruction class and the total length of each sequence. The same holds for opcode values that change during fetch without effect, and for an asynchronous reset in the middle of a load, followed by the synchronised release.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  typedef enum logic [3:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_LDRD   = 4'd3,
    ST_LDWB   = 4'd4,
    ST_STWR   = 4'd5,
    ST_REXE   = 4'd6,
    ST_RWB    = 4'd7,
    ST_BRCH   = 4'd8,
    ST_JUMP   = 4'd9
  } seq_state_e;

  localparam logic [1:0] PCS_ALU  = 2'b00;
  localparam logic [1:0] PCS_HELD = 2'b01;
  localparam logic [1:0] PCS_JMP  = 2'b10;

  localparam logic [1:0] AM_ADD   = 2'b00;
  localparam logic [1:0] AM_SUB   = 2'b01;
  localparam logic [1:0] AM_FUNCT = 2'b10;

  localparam logic [1:0] BS_REG   = 2'b00;
  localparam logic [1:0] BS_FOUR  = 2'b01;
  localparam logic [1:0] BS_IMM   = 2'b10;
  localparam logic [1:0] BS_IMMSH = 2'b11;

  typedef struct packed {
    logic       pc_ld;
    logic       pc_ld_if_zero;
    logic       addr_sel_alu;
    logic       mem_rd;
    logic       mem_wr;
    logic       instr_ld;
    logic       wb_sel_mem;
    logic [1:0] pc_src;
    logic [1:0] alu_mode;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic       rf_wr;
    logic       rf_dst_sel;
  } ctrl_t;

endpackage

// File: rtl/mc_rst_sync.sv
module mc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mc_ctrl_next.sv
module mc_ctrl_next
  import mc_ctrl_pkg::*;
#(
  parameter int             OP_W     = 6,
  parameter logic [OP_W-1:0] OP_LOAD  = 6'b100011,
  parameter logic [OP_W-1:0] OP_STORE = 6'b101011,
  parameter logic [OP_W-1:0] OP_REG   = 6'b000000,
  parameter logic [OP_W-1:0] OP_BEQ   = 6'b000100,
  parameter logic [OP_W-1:0] OP_JUMP  = 6'b000010
) (
  input  seq_state_e      state_q,
  input  logic [OP_W-1:0] opcode,
  output seq_state_e      state_d
);
  always_comb begin
    state_d = ST_FETCH;
    unique case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: begin
        if (opcode == OP_LOAD || opcode == OP_STORE) state_d = ST_ADDR;
        else if (opcode == OP_REG)                   state_d = ST_REXE;
        else if (opcode == OP_BEQ)                   state_d = ST_BRCH;
        else if (opcode == OP_JUMP)                  state_d = ST_JUMP;
        else                                         state_d = ST_FETCH;
      end
      ST_ADDR: begin
        if (opcode == OP_LOAD)       state_d = ST_LDRD;
        else if (opcode == OP_STORE) state_d = ST_STWR;
        else                         state_d = ST_FETCH;
      end
      ST_LDRD:  state_d = ST_LDWB;
      ST_REXE:  state_d = ST_RWB;
      ST_LDWB, ST_STWR, ST_RWB, ST_BRCH, ST_JUMP: state_d = ST_FETCH;
      default:  state_d = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_out.sv
module mc_ctrl_out
  import mc_ctrl_pkg::*;
(
  input  seq_state_e state_q,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    case (state_q)
      ST_FETCH: begin
        ctrl.mem_rd    = 1'b1;
        ctrl.instr_ld  = 1'b1;
        ctrl.pc_ld     = 1'b1;
        ctrl.pc_src    = PCS_ALU;
        ctrl.alu_b_sel = BS_FOUR;
        ctrl.alu_mode  = AM_ADD;
      end
      ST_DECODE: begin
        ctrl.alu_b_sel = BS_IMMSH;
        ctrl.alu_mode  = AM_ADD;
      end
      ST_ADDR: begin
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_b_sel = BS_IMM;
        ctrl.alu_mode  = AM_ADD;
      end
      ST_LDRD: begin
        ctrl.mem_rd       = 1'b1;
        ctrl.addr_sel_alu = 1'b1;
      end
      ST_LDWB: begin
        ctrl.rf_wr      = 1'b1;
        ctrl.wb_sel_mem = 1'b1;
      end
      ST_STWR: begin
        ctrl.mem_wr       = 1'b1;
        ctrl.addr_sel_alu = 1'b1;
      end
      ST_REXE: begin
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_b_sel = BS_REG;
        ctrl.alu_mode  = AM_FUNCT;
      end
      ST_RWB: begin
        ctrl.rf_wr      = 1'b1;
        ctrl.rf_dst_sel = 1'b1;
      end
      ST_BRCH: begin
        ctrl.alu_a_sel     = 1'b1;
        ctrl.alu_b_sel     = BS_REG;
        ctrl.alu_mode      = AM_SUB;
        ctrl.pc_ld_if_zero = 1'b1;
        ctrl.pc_src        = PCS_HELD;
      end
      ST_JUMP: begin
        ctrl.pc_ld  = 1'b1;
        ctrl.pc_src = PCS_JMP;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/mc_seq_ctrl.sv
module mc_seq_ctrl
  import mc_ctrl_pkg::*;
#(
  parameter int              OP_W        = 6,
  parameter int              SYNC_STAGES = 2,
  parameter logic [OP_W-1:0] OP_LOAD     = 6'b100011,
  parameter logic [OP_W-1:0] OP_STORE    = 6'b101011,
  parameter logic [OP_W-1:0] OP_REG      = 6'b000000,
  parameter logic [OP_W-1:0] OP_BEQ      = 6'b000100,
  parameter logic [OP_W-1:0] OP_JUMP     = 6'b000010
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opcode,
  output logic            pc_ld,
  output logic            pc_ld_if_zero,
  output logic            addr_sel_alu,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            instr_ld,
  output logic            wb_sel_mem,
  output logic [1:0]      pc_src,
  output logic [1:0]      alu_mode,
  output logic            alu_a_sel,
  output logic [1:0]      alu_b_sel,
  output logic            rf_wr,
  output logic            rf_dst_sel
);
  logic       rst_core_n;
  seq_state_e state_q;
  seq_state_e state_d;
  ctrl_t      ctrl;

  mc_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  mc_ctrl_next #(
    .OP_W(OP_W), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE),
    .OP_REG(OP_REG), .OP_BEQ(OP_BEQ), .OP_JUMP(OP_JUMP)
  ) i_next (
    .state_q (state_q),
    .opcode  (opcode),
    .state_d (state_d)
  );

  // The state register is cleared asynchronously by the port reset, so fetch
  // shows at once; leaving reset waits for the synchronised release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           state_q <= ST_FETCH;
    else if (!rst_core_n) state_q <= ST_FETCH;
    else                  state_q <= state_d;
  end

  mc_ctrl_out i_out (
    .state_q (state_q),
    .ctrl    (ctrl)
  );

  assign pc_ld         = ctrl.pc_ld;
  assign pc_ld_if_zero = ctrl.pc_ld_if_zero;
  assign addr_sel_alu  = ctrl.addr_sel_alu;
  assign mem_rd        = ctrl.mem_rd;
  assign mem_wr        = ctrl.mem_wr;
  assign instr_ld      = ctrl.instr_ld;
  assign wb_sel_mem    = ctrl.wb_sel_mem;
  assign pc_src        = ctrl.pc_src;
  assign alu_mode      = ctrl.alu_mode;
  assign alu_a_sel     = ctrl.alu_a_sel;
  assign alu_b_sel     = ctrl.alu_b_sel;
  assign rf_wr         = ctrl.rf_wr;
  assign rf_dst_sel    = ctrl.rf_dst_sel;
endmodule

// File: rtl/mc_seq_ctrl_chk.sv
module mc_seq_ctrl_chk #(
  parameter int              OP_W     = 6,
  parameter logic [OP_W-1:0] OP_LOAD  = 6'b100011,
  parameter logic [OP_W-1:0] OP_STORE = 6'b101011,
  parameter logic [OP_W-1:0] OP_REG   = 6'b000000,
  parameter logic [OP_W-1:0] OP_BEQ   = 6'b000100,
  parameter logic [OP_W-1:0] OP_JUMP  = 6'b000010
) (
  input logic            clk,
  input logic            rst_n,
  input logic [OP_W-1:0] opcode,
  input logic            pc_ld,
  input logic            pc_ld_if_zero,
  input logic            addr_sel_alu,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic            instr_ld,
  input logic            wb_sel_mem,
  input logic [1:0]      pc_src,
  input logic [1:0]      alu_mode,
  input logic            alu_a_sel,
  input logic [1:0]      alu_b_sel,
  input logic            rf_wr,
  input logic            rf_dst_sel
);
  logic in_decode;
  logic op_known;
  assign in_decode = (alu_b_sel == 2'b11);
  assign op_known  = (opcode == OP_LOAD) || (opcode == OP_STORE) ||
                     (opcode == OP_REG)  || (opcode == OP_BEQ)   ||
                     (opcode == OP_JUMP);

  a_r2_fetch_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    instr_ld |-> (mem_rd && pc_ld && pc_src == 2'b00 && !addr_sel_alu &&
                  alu_b_sel == 2'b01 && !rf_wr && !mem_wr));

  a_r3_decode_follows: assert property (@(posedge clk) disable iff (!rst_n)
    instr_ld |=> (in_decode && !alu_a_sel && !mem_rd && !pc_ld && !rf_wr));

  a_r4_jump_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
    (in_decode && opcode == OP_JUMP) |=> (pc_ld && pc_src == 2'b10));

  a_r5_store_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_b_sel == 2'b10 && opcode == OP_STORE) |=> (mem_wr && addr_sel_alu));

  a_r6_load_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && addr_sel_alu) |=> (rf_wr && wb_sel_mem && !rf_dst_sel));

  a_r7_store_returns: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> instr_ld);

  a_r8_reg_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_mode == 2'b10) |=> (rf_wr && rf_dst_sel && !wb_sel_mem));

  a_r9_branch_returns: assert property (@(posedge clk) disable iff (!rst_n)
    pc_ld_if_zero |=> instr_ld);

  a_r11_bad_op_refetch: assert property (@(posedge clk) disable iff (!rst_n)
    (in_decode && !op_known) |=> instr_ld);

  a_r13_mem_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r13_pc_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(pc_ld && pc_ld_if_zero));
endmodule

bind mc_seq_ctrl mc_seq_ctrl_chk #(
  .OP_W(OP_W), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE),
  .OP_REG(OP_REG), .OP_BEQ(OP_BEQ), .OP_JUMP(OP_JUMP)
) i_chk (
  .clk(clk), .rst_n(rst_core_n), .opcode(opcode),
  .pc_ld(pc_ld), .pc_ld_if_zero(pc_ld_if_zero), .addr_sel_alu(addr_sel_alu),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .instr_ld(instr_ld),
  .wb_sel_mem(wb_sel_mem), .pc_src(pc_src), .alu_mode(alu_mode),
  .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .rf_wr(rf_wr),
  .rf_dst_sel(rf_dst_sel)
);

// File: tb/test_mc_seq_ctrl.sv
`timescale 1ns/1ps
module test_mc_seq_ctrl;
  localparam logic [5:0] OP_LW  = 6'b100011;
  localparam logic [5:0] OP_SW  = 6'b101011;
  localparam logic [5:0] OP_RR  = 6'b000000;
  localparam logic [5:0] OP_BR  = 6'b000100;
  localparam logic [5:0] OP_JP  = 6'b000010;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] opcode;
  logic       pc_ld, pc_ld_if_zero, addr_sel_alu, mem_rd, mem_wr, instr_ld;
  logic       wb_sel_mem, alu_a_sel, rf_wr, rf_dst_sel;
  logic [1:0] pc_src, alu_mode, alu_b_sel;
  int         n_chk = 0;
  int         n_fail = 0;

  always #4 clk = ~clk;

  mc_seq_ctrl i_mc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode(opcode),
    .pc_ld(pc_ld), .pc_ld_if_zero(pc_ld_if_zero), .addr_sel_alu(addr_sel_alu),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .instr_ld(instr_ld),
    .wb_sel_mem(wb_sel_mem), .pc_src(pc_src), .alu_mode(alu_mode),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .rf_wr(rf_wr),
    .rf_dst_sel(rf_dst_sel)
  );

  wire [15:0] obs = {pc_ld, pc_ld_if_zero, addr_sel_alu, mem_rd, mem_wr, instr_ld,
                     wb_sel_mem, pc_src, alu_mode, alu_a_sel, alu_b_sel, rf_wr, rf_dst_sel};

  // Field order: pcl pcz adr mrd mwr irl wbm pcs[2] am[2] asel bsel[2] rfw dst
  function automatic logic [15:0] pat(int s);
    case (s)
      0: return {1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'b00,2'b00,1'b0,2'b01,1'b0,1'b0};
      1: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,2'b11,1'b0,1'b0};
      2: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b1,2'b10,1'b0,1'b0};
      3: return {1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,2'b00,1'b0,1'b0};
      4: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b00,1'b0,2'b00,1'b1,1'b0};
      5: return {1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,2'b00,2'b00,1'b0,2'b00,1'b0,1'b0};
      6: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b10,1'b1,2'b00,1'b0,1'b0};
      7: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,2'b00,1'b1,1'b1};
      8: return {1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b01,1'b1,2'b00,1'b0,1'b0};
      9: return {1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b10,2'b00,1'b0,2'b00,1'b0,1'b0};
      default: return 16'h0000;
    endcase
  endfunction

  // Step of an instruction -> expected step number, -1 when back at fetch.
  function automatic int step_of(logic [5:0] op, int st);
    case (st)
      0: return 0;
      1: return 1;
      2: if (op == OP_LW || op == OP_SW) return 2;
         else if (op == OP_RR) return 6;
         else if (op == OP_BR) return 8;
         else if (op == OP_JP) return 9;
         else return -1;
      3: if (op == OP_LW) return 3;
         else if (op == OP_SW) return 5;
         else if (op == OP_RR) return 7;
         else return -1;
      4: if (op == OP_LW) return 4; else return -1;
      default: return -1;
    endcase
  endfunction

  function automatic string tag_of(int s, int st);
    if (st == 2) return "R4";
    case (s)
      0: return "R2";
      1: return "R3";
      2: return "R5";
      3, 4: return "R6";
      5: return "R7";
      6, 7: return "R8";
      8: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic bit known(logic [5:0] op);
    return op == OP_LW || op == OP_SW || op == OP_RR || op == OP_BR || op == OP_JP;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_excl();
    n_chk++;
    if ((mem_rd && mem_wr) || (pc_ld && pc_ld_if_zero)) begin
      n_fail++;
      $display("FAIL R13 actual=%b%b%b%b expected=no overlap", mem_rd, mem_wr, pc_ld, pc_ld_if_zero);
    end
  endtask

  // Entered at a negedge with the machine in fetch; leaves in fetch.
  task automatic run_instr(logic [5:0] op);
    for (int st = 0; st < 6; st++) begin
      int s;
      s = step_of(op, st);
      if (s < 0) begin
        chk(known(op) ? "R12" : "R11", obs, pat(0));
        break;
      end
      // R3: opcode seen during fetch is irrelevant.
      opcode = (st == 0) ? 6'($urandom) : op;
      chk(tag_of(s, st), obs, pat(s));
      chk_excl();
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic release_reset();
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", obs, pat(0));
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [5:0] legal [5];
    legal[0] = OP_LW; legal[1] = OP_SW; legal[2] = OP_RR;
    legal[3] = OP_BR; legal[4] = OP_JP;
    void'($urandom(32'd2024));
    rst_n  = 1'b0;
    opcode = OP_BR;
    repeat (3) @(negedge clk);
    chk("R1", obs, pat(0));
    release_reset();

    // Directed: each class, then unrecognised opcodes near legal codes.
    for (int i = 0; i < 5; i++) run_instr(legal[i]);
    run_instr(6'b111111);
    run_instr(6'b000001);
    run_instr(6'b100010);

    // R1: asynchronous reset in the middle of a load (read step).
    opcode = OP_LW;
    repeat (3) @(negedge clk);
    chk("R6", obs, pat(3));
    rst_n = 1'b0;
    #1;
    chk("R1", obs, pat(0));
    @(negedge clk);
    release_reset();
    run_instr(OP_LW);

    // Constrained random mix.
    for (int k = 0; k < 400; k++) begin
      logic [5:0] op;
      if (($urandom % 5) == 0) op = 6'($urandom);
      else op = legal[$urandom % 5];
      run_instr(op);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule